// File: doc/BRIEF.md
# Two-Phase Elastic Word Chain

This block is a first-in first-out buffer made as a straight line of one-word stages. A word enters at the head and moves toward the tail one stage at a time. Each stage holds at most one word and a marker that says whether that word has already been copied by the next stage. Stages take turns on the two clock phases. Even-numbered stages update on the rising edge and odd-numbered stages update on the falling edge, so a word can advance one stage every half clock period. The number of stages sets both the capacity and the latency from head to tail.

Both ends use a valid/stop handshake and are sampled on the rising edge. At the head, a word transfers on a rising edge when `inValid` is high and `inStop` is low. At the tail, a word leaves on a rising edge when `outValid` is high and `outStop` is low. A stage takes a new word only when it is empty and its upstream neighbour holds a word that has not yet been copied. Inside the chain, each stage has a toggle bit. Comparing neighbouring toggles tells a stage whether it is full and whether its upstream word is new. Because of this, each stage needs only its neighbours' registered state and no combinational stop path runs along the chain. The design assumes an even stage count, which lets the tail stage and the output handshake sit on opposite phases.

Top module: `hbp_elastic_chain`

## Requirements
- R1: While `rstN` is low and on the first sample after it rises, `outValid` and `inStop` are both 0.
- R2: Every accepted word leaves exactly once, and words leave in the order in which they were accepted.
- R3: The chain accepts exactly DEPTH words while `outStop` is held high, and `inStop` is then high. Words offered while `inStop` is high, or presented with `inValid` low, are never taken.
- R4: A word accepted into an empty chain on rising edge k is presented with `outValid` high before rising edge k+DEPTH/2. It is not yet presented before edge k+DEPTH/2-1.
- R5: If one word is removed from a full chain on rising edge k, with no pushes or pops after it, `inStop` is low before edge k+DEPTH/2 and still high before edge k+DEPTH/2-1.
- R6: While `outValid` is high and `outStop` is high, `outValid` stays high and `outData` holds its value on the next edge.
- R7: Suppose the chain holds DEPTH/2 words that have reached the tail, and a push and a pop are offered on every edge. Then every edge both accepts and delivers one word.
- R8: A full chain with `outStop` held low delivers DEPTH words on DEPTH consecutive rising edges.
- R9: `outValid` is 0 whenever the chain holds no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; even stages act on the rising edge, odd stages on the falling edge |
| rstN | input | 1 | Asynchronous active-low reset; clears every stage's state |
| inValid | input | 1 | Head offers a word |
| inData | input | WIDTH | Word offered at the head |
| inStop | output | 1 | Head stage is occupied; the offered word is not taken |
| outValid | output | 1 | Tail stage presents a word |
| outData | output | WIDTH | Word presented at the tail |
| outStop | input | 1 | Consumer refuses the presented word |

## Verification
The hardest state to reach from the ports is the steady exchange at exactly half occupancy. There the DEPTH/2 stored words must already sit at the tail before the first simultaneous push and pop, or the forward latency hides a stall. The bench gets there by loading DEPTH/2 words with the tail blocked and letting them settle for DEPTH cycles. It then opens both ends and counts any edge on which either end stalls. The backward-latency case is built in a similar way: the chain is filled to the brim, exactly one word is released, and both ends are frozen. This lets the bench time how long the single gap takes to travel back to the head.

// File: rtl/hbp_pkg.sv
`timescale 1ns/1ps
package hbp_pkg;

  // Clock level on which a stage updates its state
  typedef enum logic {
    PH_HIGH = 1'b0,   // rising-edge stage
    PH_LOW  = 1'b1    // falling-edge stage
  } phase_e;

  // Strobe from control to datapath for one stage
  typedef struct packed {
    logic load;       // stage copies its upstream word on its own edge
  } stageStrobe_t;

  // Neighbouring stages sit on opposite phases; the head is a rising-edge stage
  function automatic phase_e stagePhase(input int idx);
    return (idx % 2 == 0) ? PH_HIGH : PH_LOW;
  endfunction

endpackage

// File: rtl/hbp_ctrl.sv
`timescale 1ns/1ps
module hbp_ctrl
  import hbp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  output logic                      inStop,
  output logic                      outValid,
  input  logic                      outStop,
  output stageStrobe_t [DEPTH-1:0]  strobe
);

  // tog[DEPTH] belongs to the consumer side of the tail handshake
  logic [DEPTH:0]   tog;
  logic [DEPTH-1:0] isFull;
  logic [DEPTH-1:0] upNew;
  logic             sinkQ;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic togQ;

    // a stage is occupied while its word has not been copied downstream
    assign isFull[i] = tog[i] ^ tog[i+1];

    if (i == 0) begin : g_head
      assign upNew[i] = inValid;
    end else begin : g_body
      assign upNew[i] = tog[i-1] ^ tog[i];
    end

    assign strobe[i].load = upNew[i] & ~isFull[i];

    if (stagePhase(i) == PH_HIGH) begin : g_rise
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                togQ <= 1'b0;
        else if (strobe[i].load)  togQ <= ~togQ;
      end
    end else begin : g_fall
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN)                togQ <= 1'b0;
        else if (strobe[i].load)  togQ <= ~togQ;
      end
    end

    assign tog[i] = togQ;
  end

  // consumer acknowledgement toggles on each accepted pop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     sinkQ <= 1'b0;
    else if (outValid && !outStop) sinkQ <= ~sinkQ;
  end

  assign tog[DEPTH] = sinkQ;
  assign inStop     = isFull[0];
  assign outValid   = isFull[DEPTH-1];

endmodule

// File: rtl/hbp_data.sv
`timescale 1ns/1ps
module hbp_data
  import hbp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic                      clk,
  input  stageStrobe_t [DEPTH-1:0]  strobe,
  input  logic [WIDTH-1:0]          inData,
  output logic [WIDTH-1:0]          outData
);

  logic [DEPTH-1:0][WIDTH-1:0] word;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] wordQ;

    if (i == 0) begin : g_head
      assign src = inData;
    end else begin : g_body
      assign src = word[i-1];
    end

    // data words carry no reset; occupancy lives entirely in the control toggles
    if (stagePhase(i) == PH_HIGH) begin : g_rise
      always_ff @(posedge clk) begin
        if (strobe[i].load) wordQ <= src;
      end
    end else begin : g_fall
      always_ff @(negedge clk) begin
        if (strobe[i].load) wordQ <= src;
      end
    end

    assign word[i] = wordQ;
  end

  assign outData = word[DEPTH-1];

endmodule

// File: rtl/hbp_elastic_chain.sv
`timescale 1ns/1ps
module hbp_elastic_chain
  import hbp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inData,
  output logic             inStop,
  output logic             outValid,
  output logic [WIDTH-1:0] outData,
  input  logic             outStop
);

  stageStrobe_t [DEPTH-1:0] strobe;

  hbp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inStop   (inStop),
    .outValid (outValid),
    .outStop  (outStop),
    .strobe   (strobe)
  );

  hbp_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk     (clk),
    .strobe  (strobe),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/hbp_checker.sv
`timescale 1ns/1ps
module hbp_checker #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inStop,
  input logic             outValid,
  input logic [WIDTH-1:0] outData,
  input logic             outStop
);

  localparam int OCC_W = $clog2(DEPTH + 1) + 1;

  logic [OCC_W-1:0] occ;
  logic             pushOk;
  logic             popOk;

  assign pushOk = inValid && !inStop;
  assign popOk  = outValid && !outStop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= '0;
    else       occ <= occ + OCC_W'(pushOk) - OCC_W'(popOk);
  end

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_clear_r1: assert (!outValid && !inStop)
        else $error("R1: outputs not cleared during reset");
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(DEPTH));

  p_full_stops_r3: assert property (@(posedge clk) disable iff (!rstN)
    (occ == OCC_W'(DEPTH)) |-> inStop);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStop) |=> (outValid && $stable(outData)));

  p_empty_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0) |-> !outValid);

endmodule

bind hbp_elastic_chain hbp_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inStop   (inStop),
  .outValid (outValid),
  .outData  (outData),
  .outStop  (outStop)
);

// File: tb/sim_hbp_elastic_chain.sv
`timescale 1ns/1ps
module sim_hbp_elastic_chain;

  localparam int DEPTH = 8;
  localparam int WIDTH = 16;
  localparam int HALF  = DEPTH / 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b1;
  logic             inValid = 1'b0;
  logic [WIDTH-1:0] inData = '0;
  logic             inStop;
  logic             outValid;
  logic [WIDTH-1:0] outData;
  logic             outStop = 1'b1;

  int checks = 0;
  int fails = 0;
  int pushCnt = 0;
  int popCnt = 0;
  bit done = 1'b0;

  logic [WIDTH-1:0] sb[$];
  logic             sInStop;
  logic             sOutValid;
  logic [WIDTH-1:0] sOutData;

  always #10 clk = ~clk;   // 50 MHz

  hbp_elastic_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inStop(inStop),
    .outValid(outValid), .outData(outData), .outStop(outStop)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: enter 5 ns after a rising edge, drive, sample at +15 ns, leave at next +5 ns.
  task automatic step(input logic iv, input logic [WIDTH-1:0] id, input logic os);
    inValid = iv;
    inData  = id;
    outStop = os;
    #10;
    sInStop   = inStop;
    sOutValid = outValid;
    sOutData  = outData;
    if (iv && !sInStop) begin
      sb.push_back(id);
      pushCnt++;
    end
    if (sOutValid && !os) begin
      popCnt++;
      if (sb.size() == 0) begin
        check(1'b0, "R2", "word delivered that was never accepted", 1, 0);
      end else begin
        logic [WIDTH-1:0] exp;
        exp = sb.pop_front();
        check(sOutData == exp, "R2", "delivered word", int'(sOutData), int'(exp));
      end
    end
    @(posedge clk);
    #5;
  endtask

  task automatic drain();
    repeat (3 * DEPTH) step(1'b0, '0, 1'b0);
    check(sb.size() == 0, "R2", "words left undelivered", sb.size(), 0);
  endtask

  task automatic t_reset();
    #1 rstN = 1'b0;
    @(posedge clk);
    #15;
    check(!outValid, "R1", "outValid in reset", int'(outValid), 0);
    check(!inStop, "R1", "inStop in reset", int'(inStop), 0);
    @(posedge clk);
    #5 rstN = 1'b1;
    step(1'b0, '0, 1'b1);
    check(!sOutValid && !sInStop, "R1", "outputs after reset release",
          int'({sOutValid, sInStop}), 0);
  endtask

  task automatic t_latency();
    step(1'b1, 16'hA5C3, 1'b1);
    check(!sInStop, "R4", "push into empty chain refused", int'(sInStop), 0);
    for (int j = 1; j <= HALF; j++) begin
      step(1'b0, '0, 1'b1);
      if (j == HALF - 1)
        check(!sOutValid, "R4", "word visible too early", int'(sOutValid), 0);
      if (j == HALF) begin
        check(sOutValid, "R4", "word not visible after DEPTH/2 cycles", int'(sOutValid), 1);
        check(sOutData == 16'hA5C3, "R4", "word at tail", int'(sOutData), 'hA5C3);
      end
    end
    drain();
    check(!sOutValid, "R9", "outValid on empty chain", int'(sOutValid), 0);
  endtask

  task automatic t_ignore_idle();
    for (int j = 0; j < 6; j++) step(1'b0, 16'hFFFF - 16'(j), 1'b0);
    check(!sOutValid, "R3", "data without inValid was taken", int'(sOutValid), 0);
    check(sb.size() == 0, "R9", "scoreboard after idle", sb.size(), 0);
  endtask

  task automatic t_fill_hold();
    int taken;
    logic [WIDTH-1:0] held;
    taken = 0;
    for (int j = 0; j < 2 * DEPTH; j++) begin
      step(1'b1, 16'h1000 + 16'(j), 1'b1);
      if (!sInStop) taken++;
    end
    check(taken == DEPTH, "R3", "words accepted with tail blocked", taken, DEPTH);
    check(sInStop, "R3", "inStop when full", int'(sInStop), 1);
    check(sOutValid && sOutData == 16'h1000, "R6", "oldest word held at tail",
          int'(sOutData), 'h1000);
    held = sOutData;
    taken = pushCnt;
    repeat (5) step(1'b1, 16'hBEEF, 1'b1);
    check(pushCnt == taken, "R3", "push taken while inStop high", pushCnt - taken, 0);
    check(sOutValid && sOutData == held, "R6", "tail word changed under stop",
          int'(sOutData), int'(held));
  endtask

  task automatic t_backward();
    step(1'b0, '0, 1'b0);
    check(sOutValid, "R5", "full chain had no word to release", int'(sOutValid), 1);
    for (int j = 1; j <= HALF; j++) begin
      step(1'b0, '0, 1'b1);
      if (j == HALF - 1)
        check(sInStop, "R5", "space reached head too early", int'(sInStop), 1);
      if (j == HALF)
        check(!sInStop, "R5", "space not at head after DEPTH/2 cycles", int'(sInStop), 0);
    end
  endtask

  task automatic t_drain_full();
    int run;
    step(1'b1, 16'h2000, 1'b1);
    repeat (DEPTH) step(1'b0, '0, 1'b1);
    check(sInStop, "R3", "chain not full after refill", int'(sInStop), 1);
    run = 0;
    for (int j = 0; j < DEPTH + 2; j++) begin
      step(1'b0, '0, 1'b0);
      if (sOutValid && j == run) run++;
    end
    check(run == DEPTH, "R8", "back-to-back words from full chain", run, DEPTH);
    check(!sOutValid, "R9", "outValid after draining", int'(sOutValid), 0);
    check(sb.size() == 0, "R2", "words left after drain", sb.size(), 0);
  endtask

  task automatic t_half_rate();
    int stalls;
    for (int j = 0; j < HALF; j++) step(1'b1, 16'h3000 + 16'(j), 1'b1);
    repeat (DEPTH) step(1'b0, '0, 1'b1);
    stalls = 0;
    for (int j = 0; j < 3 * DEPTH; j++) begin
      step(1'b1, 16'h3100 + 16'(j), 1'b0);
      if (sInStop || !sOutValid) stalls++;
    end
    check(stalls == 0, "R7", "stalled edges at half occupancy", stalls, 0);
    drain();
  endtask

  task automatic t_mixed();
    int p0;
    int q0;
    p0 = pushCnt;
    q0 = popCnt;
    for (int j = 0; j < 200; j++) begin
      step((j % 3) != 1, 16'(j * 37) ^ 16'h5A5A, ((j % 5) == 2) || ((j % 7) == 0));
    end
    drain();
    check((pushCnt - p0) == (popCnt - q0), "R2", "accepted vs delivered in mixed traffic",
          popCnt - q0, pushCnt - p0);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_ignore_idle();
    t_fill_hold();
    t_backward();
    t_drain_full();
    t_half_rate();
    t_mixed();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule